// File: doc/BRIEF.md
# Trap CSR Write Legalizer

This block owns the write path and storage of the machine-level and supervisor-level trap control registers of a hart. Each write passes through a per-register legality filter, so that only bits the hart actually implements are ever stored. Reads of any register return the stored value, which is therefore always legal. The block holds the interrupt enable and pending words, both delegation words, both exception program counters, both trap vector bases, the extension word and both counter-enable words. It also serves the supervisor views of the pending and enable words, which are windows onto the machine copies filtered by the interrupt delegation word.

A request is one cycle of `csr_req`, with `csr_we` selecting a write. Each request returns one registered response on the next cycle, carrying the value the register held before the request and an illegal-access flag. The privilege level given with each request decides whether the user-level counter window may be read. The counter values themselves live outside this block, so permitted counter reads return zero.

Top module: `trap_csr_legalizer`

## Requirements
- R1: After synchronous reset no response is pending, every held register reads zero, and the extension word (address 0x301) reads the supported mask in bits 25:0 with the width code in the top two bits (1 for XLEN 32, 2 for XLEN 64).
- R2: Writes to the machine pending word (0x344) change only bits 1 and 5; every other bit stays zero.
- R3: Writes to the interrupt delegation word (0x303) change only bits 1, 5, 9 and 12.
- R4: Writes to the exception delegation word (0x302) change only bits 0, 3, 8, 12, 13 and 15.
- R5: Writes to the machine enable word (0x304) change only bits 1, 3, 5, 7, 9 and 12.
- R6: A write to either exception program counter (0x341 machine, 0x141 supervisor) stores the value with bit 0 cleared; the supervisor vector base (0x105) stores it with bits 1:0 cleared; the machine vector base (0x305) stores it with bit 1 cleared.
- R7: Reads of the supervisor pending view (0x144) and enable view (0x104) return the machine pending and enable words ANDed with the interrupt delegation word.
- R8: A write to the supervisor enable view changes only machine enable bits that are set in the delegation word; a write to the supervisor pending view changes only pending bit 1, and only while delegation bit 1 is set.
- R9: In the extension word only bits 12, 0, 5, 3 and 2 are writable, each only if set in the supported mask; a write with bit 5 clear also clears bit 3; the width code never changes.
- R10: A read in the counter window 0xC00 to 0xC1F at privilege 3 is always permitted; at privilege 1 or 2 it needs bit (address mod 32) of the machine counter-enable word (0x306); at privilege 0 it also needs that bit of the supervisor counter-enable word (0x106). A denied read raises the illegal flag. Permitted reads return zero.
- R11: An access to any other address, or a write into the counter window, raises the illegal flag, returns zero data and leaves every register unchanged.
- R12: Every request produces exactly one response on the following cycle, and its data is the register value before that request's write; back-to-back requests are served one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | Request valid for one cycle |
| csr_we | input | 1 | Request is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_priv | input | 2 | Privilege of the requester: 0 user, 1 supervisor, 3 machine |
| ext_mask | input | 26 | Supported extension bits, loaded into the extension word at reset |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | XLEN | Pre-write register value, zero on an illegal access |
| rsp_illegal | output | 1 | Access was refused |

## Verification
The bound checker watches, on every cycle, the one-cycle response timing, that the pending word never holds an unwritable bit, the alignment of the machine program counter and supervisor vector base, that the supervisor pending view never leaks an undelegated bit, the coupling of the double and single float bits in the extension word, denial of unpermitted user counter reads, and that a refused access leaves state untouched. The exact legal masks of each register, the read-before-write value, the delegation-gated writes through the supervisor views and the step-by-step enabling of the counter window by the two enable words are shown only by the bench's scenarios, which write all-ones and patterned data and read the results back.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

  localparam int ADDR_W = 12;
  localparam int EXT_W  = 26;
  localparam int CEN_W  = 32;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SIE, SEL_STVEC, SEL_SCEN, SEL_SEPC, SEL_SIP,
    SEL_MISA, SEL_MEDELEG, SEL_MIDELEG, SEL_MIE, SEL_MTVEC,
    SEL_MCEN, SEL_MEPC, SEL_MIP, SEL_CNT
  } csr_sel_e;

  localparam logic [ADDR_W-1:0] A_SIE     = 12'h104;
  localparam logic [ADDR_W-1:0] A_STVEC   = 12'h105;
  localparam logic [ADDR_W-1:0] A_SCEN    = 12'h106;
  localparam logic [ADDR_W-1:0] A_SEPC    = 12'h141;
  localparam logic [ADDR_W-1:0] A_SIP     = 12'h144;
  localparam logic [ADDR_W-1:0] A_MISA    = 12'h301;
  localparam logic [ADDR_W-1:0] A_MEDELEG = 12'h302;
  localparam logic [ADDR_W-1:0] A_MIDELEG = 12'h303;
  localparam logic [ADDR_W-1:0] A_MIE     = 12'h304;
  localparam logic [ADDR_W-1:0] A_MTVEC   = 12'h305;
  localparam logic [ADDR_W-1:0] A_MCEN    = 12'h306;
  localparam logic [ADDR_W-1:0] A_MEPC    = 12'h341;
  localparam logic [ADDR_W-1:0] A_MIP     = 12'h344;
  localparam logic [6:0]        A_CNT_HI  = 7'h60;

  // legal-bit masks (zero-extended to XLEN where used)
  localparam logic [63:0] M_PEND   = 64'h0000_0022;
  localparam logic [63:0] M_IDELEG = 64'h0000_1222;
  localparam logic [63:0] M_EDELEG = 64'h0000_B109;
  localparam logic [63:0] M_IEN    = 64'h0000_12AA;
  localparam logic [63:0] M_SSOFT  = 64'h0000_0002;

  localparam int X_A = 0;
  localparam int X_C = 2;
  localparam int X_D = 3;
  localparam int X_F = 5;
  localparam int X_M = 12;
  localparam logic [EXT_W-1:0] M_EXT =
    (EXT_W'(1) << X_M) | (EXT_W'(1) << X_A) | (EXT_W'(1) << X_F) |
    (EXT_W'(1) << X_D) | (EXT_W'(1) << X_C);

endpackage

// File: rtl/trap_csr_decode.sv
module trap_csr_decode
  import trap_csr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [1:0]        priv,
  input  logic [CEN_W-1:0]  mcen,
  input  logic [CEN_W-1:0]  scen,
  output csr_sel_e          sel,
  output logic              illegal
);
  logic [4:0] idx;
  logic       permit;

  assign idx    = addr[4:0];
  assign permit = (priv == PRIV_M) ||
                  (mcen[idx] && ((priv != PRIV_U) || scen[idx]));

  always_comb begin
    sel     = SEL_NONE;
    illegal = 1'b0;
    case (addr)
      A_SIE:     sel = SEL_SIE;
      A_STVEC:   sel = SEL_STVEC;
      A_SCEN:    sel = SEL_SCEN;
      A_SEPC:    sel = SEL_SEPC;
      A_SIP:     sel = SEL_SIP;
      A_MISA:    sel = SEL_MISA;
      A_MEDELEG: sel = SEL_MEDELEG;
      A_MIDELEG: sel = SEL_MIDELEG;
      A_MIE:     sel = SEL_MIE;
      A_MTVEC:   sel = SEL_MTVEC;
      A_MCEN:    sel = SEL_MCEN;
      A_MEPC:    sel = SEL_MEPC;
      A_MIP:     sel = SEL_MIP;
      default: begin
        if (addr[11:5] == A_CNT_HI) begin
          sel     = SEL_CNT;
          illegal = we | ~permit;
        end else begin
          illegal = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/trap_csr_state.sv
module trap_csr_state
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  csr_sel_e         sel,
  input  logic [XLEN-1:0]  wdata,
  input  logic [EXT_W-1:0] ext_mask,
  output logic [XLEN-1:0]  mie_q,
  output logic [XLEN-1:0]  mip_q,
  output logic [XLEN-1:0]  mideleg_q,
  output logic [XLEN-1:0]  medeleg_q,
  output logic [XLEN-1:0]  mepc_q,
  output logic [XLEN-1:0]  sepc_q,
  output logic [XLEN-1:0]  mtvec_q,
  output logic [XLEN-1:0]  stvec_q,
  output logic [EXT_W-1:0] misa_q,
  output logic [CEN_W-1:0] mcen_q,
  output logic [CEN_W-1:0] scen_q
);
  localparam logic [XLEN-1:0] PEND_W  = M_PEND[XLEN-1:0];
  localparam logic [XLEN-1:0] IDEL_W  = M_IDELEG[XLEN-1:0];
  localparam logic [XLEN-1:0] EDEL_W  = M_EDELEG[XLEN-1:0];
  localparam logic [XLEN-1:0] IEN_W   = M_IEN[XLEN-1:0];
  localparam logic [XLEN-1:0] SSOFT_W = M_SSOFT[XLEN-1:0];

  logic [EXT_W-1:0] ext_in, ext_wm;
  logic [XLEN-1:0]  sie_m, sip_m;

  always_comb begin
    ext_in = wdata[EXT_W-1:0];
    if (!ext_in[X_F]) ext_in[X_D] = 1'b0;
    ext_wm = M_EXT & ext_mask;
  end

  assign sie_m = mideleg_q & IEN_W;
  assign sip_m = mideleg_q & SSOFT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      mie_q     <= '0;
      mip_q     <= '0;
      mideleg_q <= '0;
      medeleg_q <= '0;
      mepc_q    <= '0;
      sepc_q    <= '0;
      mtvec_q   <= '0;
      stvec_q   <= '0;
      misa_q    <= ext_mask;
      mcen_q    <= '0;
      scen_q    <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_MIE:     mie_q     <= (mie_q & ~IEN_W) | (wdata & IEN_W);
        SEL_SIE:     mie_q     <= (mie_q & ~sie_m) | (wdata & sie_m);
        SEL_MIP:     mip_q     <= (mip_q & ~PEND_W) | (wdata & PEND_W);
        SEL_SIP:     mip_q     <= (mip_q & ~sip_m) | (wdata & sip_m);
        SEL_MIDELEG: mideleg_q <= wdata & IDEL_W;
        SEL_MEDELEG: medeleg_q <= wdata & EDEL_W;
        SEL_MEPC:    mepc_q    <= {wdata[XLEN-1:1], 1'b0};
        SEL_SEPC:    sepc_q    <= {wdata[XLEN-1:1], 1'b0};
        SEL_MTVEC:   mtvec_q   <= {wdata[XLEN-1:2], 1'b0, wdata[0]};
        SEL_STVEC:   stvec_q   <= {wdata[XLEN-1:2], 2'b00};
        SEL_MISA:    misa_q    <= (ext_in & ext_wm) | (misa_q & ~ext_wm);
        SEL_MCEN:    mcen_q    <= wdata[CEN_W-1:0];
        SEL_SCEN:    scen_q    <= wdata[CEN_W-1:0];
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/trap_csr_rdmux.sv
module trap_csr_rdmux
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_sel_e         sel,
  input  logic [XLEN-1:0]  mie_q,
  input  logic [XLEN-1:0]  mip_q,
  input  logic [XLEN-1:0]  mideleg_q,
  input  logic [XLEN-1:0]  medeleg_q,
  input  logic [XLEN-1:0]  mepc_q,
  input  logic [XLEN-1:0]  sepc_q,
  input  logic [XLEN-1:0]  mtvec_q,
  input  logic [XLEN-1:0]  stvec_q,
  input  logic [EXT_W-1:0] misa_q,
  input  logic [CEN_W-1:0] mcen_q,
  input  logic [CEN_W-1:0] scen_q,
  output logic [XLEN-1:0]  rdata
);
  localparam logic [1:0] WCODE = (XLEN == 64) ? 2'd2 : 2'd1;

  logic [XLEN-1:0] misa_view;

  always_comb begin
    misa_view = XLEN'(misa_q);
    misa_view[XLEN-1:XLEN-2] = WCODE;
  end

  always_comb begin
    case (sel)
      SEL_MIE:     rdata = mie_q;
      SEL_SIE:     rdata = mie_q & mideleg_q;
      SEL_MIP:     rdata = mip_q;
      SEL_SIP:     rdata = mip_q & mideleg_q;
      SEL_MIDELEG: rdata = mideleg_q;
      SEL_MEDELEG: rdata = medeleg_q;
      SEL_MEPC:    rdata = mepc_q;
      SEL_SEPC:    rdata = sepc_q;
      SEL_MTVEC:   rdata = mtvec_q;
      SEL_STVEC:   rdata = stvec_q;
      SEL_MISA:    rdata = misa_view;
      SEL_MCEN:    rdata = XLEN'(mcen_q);
      SEL_SCEN:    rdata = XLEN'(scen_q);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/trap_csr_legalizer.sv
module trap_csr_legalizer
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_req,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [1:0]        csr_priv,
  input  logic [25:0]       ext_mask,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic              rsp_illegal
);
  csr_sel_e         sel;
  logic             dec_illegal;
  logic             wr_en;
  logic [XLEN-1:0]  mux_data;
  logic [XLEN-1:0]  mie_q, mip_q, mideleg_q, medeleg_q;
  logic [XLEN-1:0]  mepc_q, sepc_q, mtvec_q, stvec_q;
  logic [EXT_W-1:0] misa_q;
  logic [CEN_W-1:0] mcen_q, scen_q;

  assign wr_en = csr_req & csr_we & ~dec_illegal;

  trap_csr_decode u_dec (
    .addr(csr_addr), .we(csr_we), .priv(csr_priv),
    .mcen(mcen_q), .scen(scen_q), .sel(sel), .illegal(dec_illegal)
  );

  trap_csr_state #(.XLEN(XLEN)) u_state (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(csr_wdata),
    .ext_mask(ext_mask), .mie_q(mie_q), .mip_q(mip_q),
    .mideleg_q(mideleg_q), .medeleg_q(medeleg_q), .mepc_q(mepc_q),
    .sepc_q(sepc_q), .mtvec_q(mtvec_q), .stvec_q(stvec_q),
    .misa_q(misa_q), .mcen_q(mcen_q), .scen_q(scen_q)
  );

  trap_csr_rdmux #(.XLEN(XLEN)) u_rd (
    .sel(sel), .mie_q(mie_q), .mip_q(mip_q), .mideleg_q(mideleg_q),
    .medeleg_q(medeleg_q), .mepc_q(mepc_q), .sepc_q(sepc_q),
    .mtvec_q(mtvec_q), .stvec_q(stvec_q), .misa_q(misa_q),
    .mcen_q(mcen_q), .scen_q(scen_q), .rdata(mux_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid   <= csr_req;
      rsp_illegal <= csr_req & dec_illegal;
      rsp_rdata   <= (csr_req && !dec_illegal) ? mux_data : '0;
    end
  end
endmodule

// File: rtl/trap_csr_checker.sv
module trap_csr_checker
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             csr_req,
  input logic             csr_we,
  input logic [11:0]      csr_addr,
  input logic [1:0]       csr_priv,
  input logic             rsp_valid,
  input logic [XLEN-1:0]  rsp_rdata,
  input logic             rsp_illegal,
  input logic             dec_illegal,
  input logic [XLEN-1:0]  mideleg_q,
  input logic [XLEN-1:0]  mie_q,
  input logic [XLEN-1:0]  mip_q,
  input logic [XLEN-1:0]  mepc_q,
  input logic [XLEN-1:0]  stvec_q,
  input logic [EXT_W-1:0] misa_q,
  input logic [CEN_W-1:0] mcen_q
);
  localparam logic [XLEN-1:0] PEND_W = M_PEND[XLEN-1:0];

  assert_resp_timing_R12: assert property (@(posedge clk) disable iff (rst)
    csr_req |=> rsp_valid);
  assert_no_stray_resp_R12: assert property (@(posedge clk) disable iff (rst)
    !csr_req |=> !rsp_valid);
  assert_pend_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (mip_q & ~PEND_W) == '0);
  assert_align_R6: assert property (@(posedge clk) disable iff (rst)
    (mepc_q[0] == 1'b0) && (stvec_q[1:0] == 2'b00));
  assert_sview_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_illegal && $past(csr_addr) == A_SIP)
      |-> ((rsp_rdata & ~mideleg_q) == '0));
  assert_ext_fd_R9: assert property (@(posedge clk) disable iff (rst)
    !misa_q[X_F] |-> !misa_q[X_D]);
  assert_cnt_deny_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_req && !csr_we && csr_addr[11:5] == A_CNT_HI &&
     csr_priv == PRIV_U && !mcen_q[csr_addr[4:0]]) |=> rsp_illegal);
  assert_illegal_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (csr_req && dec_illegal) |=> ($stable(mie_q) && $stable(mip_q) &&
      $stable(mideleg_q) && $stable(mepc_q) && $stable(misa_q) &&
      rsp_illegal && rsp_rdata == '0));
endmodule

bind trap_csr_legalizer trap_csr_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .csr_req(csr_req), .csr_we(csr_we),
  .csr_addr(csr_addr), .csr_priv(csr_priv), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal),
  .dec_illegal(dec_illegal), .mideleg_q(mideleg_q), .mie_q(mie_q),
  .mip_q(mip_q), .mepc_q(mepc_q), .stvec_q(stvec_q), .misa_q(misa_q),
  .mcen_q(mcen_q)
);

// File: tb/test_trap_csr_legalizer.sv
module test_trap_csr_legalizer;
  localparam int  XLEN   = 32;
  localparam time CLK_P  = 10ns;
  localparam logic [25:0] EXT = 26'h14112D;

  typedef struct {
    logic [XLEN-1:0] data;
    logic            ill;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            csr_req = 1'b0;
  logic            csr_we = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [1:0]      csr_priv = 2'd3;
  logic            rsp_valid;
  logic [XLEN-1:0] rsp_rdata;
  logic            rsp_illegal;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   finished = 0;

  always #(CLK_P/2) clk = ~clk;

  trap_csr_legalizer #(.XLEN(XLEN)) i_trap_csr_legalizer (
    .clk(clk), .rst(rst), .csr_req(csr_req), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_priv(csr_priv),
    .ext_mask(EXT), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_illegal(rsp_illegal)
  );

  task automatic access(input logic [11:0] a, input logic w,
                        input logic [XLEN-1:0] d, input logic [1:0] p,
                        input logic [XLEN-1:0] ed, input logic ei,
                        input string tag);
    exp_t e;
    @(negedge clk);
    csr_req = 1'b1; csr_we = w; csr_addr = a; csr_wdata = d; csr_priv = p;
    e.data = ed; e.ill = ei; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rd(input logic [11:0] a, input logic [XLEN-1:0] ed, input string tag);
    access(a, 1'b0, '0, 2'd3, ed, 1'b0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [XLEN-1:0] d,
                    input logic [XLEN-1:0] old, input string tag);
    access(a, 1'b1, d, 2'd3, old, 1'b0, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    csr_req = 1'b0; csr_we = 1'b0;
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R12 unexpected response got data=%h ill=%b expected none",
                 rsp_rdata, rsp_illegal);
      end else begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (rsp_rdata !== e.data || rsp_illegal !== e.ill) begin
          bad++;
          $display("FAIL %s got data=%h ill=%b expected data=%h ill=%b",
                   e.tag, rsp_rdata, rsp_illegal, e.data, e.ill);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 rsp_valid got %b expected 0", rsp_valid);
    end
    // R1 reset values
    rd(12'h304, 32'h0, "R1 mie reset");
    rd(12'h344, 32'h0, "R1 mip reset");
    rd(12'h303, 32'h0, "R1 mideleg reset");
    rd(12'h302, 32'h0, "R1 medeleg reset");
    rd(12'h341, 32'h0, "R1 mepc reset");
    rd(12'h306, 32'h0, "R1 mcen reset");
    rd(12'h301, 32'h4014112D, "R1 misa reset");
    // R2..R5 masks, back-to-back write then read (R12 old value)
    wr(12'h344, 32'hFFFFFFFF, 32'h0, "R2 mip write");
    rd(12'h344, 32'h00000022, "R2 mip legal");
    wr(12'h303, 32'hFFFFFFFF, 32'h0, "R3 mideleg write");
    rd(12'h303, 32'h00001222, "R3 mideleg legal");
    wr(12'h302, 32'hFFFFFFFF, 32'h0, "R4 medeleg write");
    rd(12'h302, 32'h0000B109, "R4 medeleg legal");
    wr(12'h304, 32'hFFFFFFFF, 32'h0, "R5 mie write");
    rd(12'h304, 32'h000012AA, "R5 mie legal");
    // R6 alignment
    wr(12'h341, 32'hFFFFFFFF, 32'h0, "R6 mepc write");
    rd(12'h341, 32'hFFFFFFFE, "R6 mepc bit0");
    wr(12'h141, 32'h12345679, 32'h0, "R6 sepc write");
    rd(12'h141, 32'h12345678, "R6 sepc bit0");
    wr(12'h105, 32'hFFFFFFFF, 32'h0, "R6 stvec write");
    rd(12'h105, 32'hFFFFFFFC, "R6 stvec low2");
    wr(12'h305, 32'hFFFFFFFF, 32'h0, "R6 mtvec write");
    rd(12'h305, 32'hFFFFFFFD, "R6 mtvec bit1");
    // R12 read-before-write
    wr(12'h341, 32'h00000100, 32'hFFFFFFFE, "R12 old value");
    rd(12'h341, 32'h00000100, "R12 new value");
    idle();
    // R7 supervisor views
    rd(12'h144, 32'h00000022, "R7 sip view full deleg");
    rd(12'h104, 32'h00001222, "R7 sie view full deleg");
    wr(12'h303, 32'h00000020, 32'h00001222, "R7 mideleg narrow");
    rd(12'h104, 32'h00000020, "R7 sie view narrow");
    rd(12'h144, 32'h00000020, "R7 sip view narrow");
    // R8 gated writes
    wr(12'h104, 32'h0, 32'h00000020, "R8 sie write");
    rd(12'h304, 32'h0000128A, "R8 sie touched only deleg bits");
    wr(12'h144, 32'h0, 32'h00000020, "R8 sip write undelegated");
    rd(12'h344, 32'h00000022, "R8 sip no effect");
    wr(12'h303, 32'h00000002, 32'h00000020, "R8 mideleg ssoft");
    wr(12'h144, 32'h0, 32'h00000002, "R8 sip write delegated");
    rd(12'h344, 32'h00000020, "R8 sip cleared ssoft");
    // R9 extension word
    wr(12'h301, 32'h0, 32'h4014112D, "R9 misa clear");
    rd(12'h301, 32'h40140100, "R9 misa writable bits");
    wr(12'h301, 32'h00000028, 32'h40140100, "R9 misa F and D");
    rd(12'h301, 32'h40140128, "R9 misa F D set");
    wr(12'h301, 32'h00000008, 32'h40140128, "R9 misa D without F");
    rd(12'h301, 32'h40140100, "R9 misa D forced clear");
    wr(12'h301, 32'hFFFFFFFF, 32'h40140100, "R9 misa all ones");
    rd(12'h301, 32'h4014112D, "R9 misa width code kept");
    // R10 counter window
    access(12'hC01, 1'b0, '0, 2'd3, 32'h0, 1'b0, "R10 machine read");
    access(12'hC01, 1'b0, '0, 2'd1, 32'h0, 1'b1, "R10 super denied");
    access(12'hC01, 1'b0, '0, 2'd0, 32'h0, 1'b1, "R10 user denied");
    wr(12'h306, 32'h00000002, 32'h0, "R10 mcen write");
    access(12'hC01, 1'b0, '0, 2'd1, 32'h0, 1'b0, "R10 super permitted");
    access(12'hC01, 1'b0, '0, 2'd0, 32'h0, 1'b1, "R10 user needs scen");
    wr(12'h106, 32'h00000002, 32'h0, "R10 scen write");
    access(12'hC01, 1'b0, '0, 2'd0, 32'h0, 1'b0, "R10 user permitted");
    access(12'hC00, 1'b0, '0, 2'd0, 32'h0, 1'b1, "R10 user other bit");
    // R11 illegal accesses
    access(12'h300, 1'b1, 32'hFFFFFFFF, 2'd3, 32'h0, 1'b1, "R11 unimplemented write");
    access(12'hC01, 1'b1, 32'hFFFFFFFF, 2'd3, 32'h0, 1'b1, "R11 counter write");
    rd(12'h304, 32'h0000128A, "R11 mie unchanged");
    rd(12'h344, 32'h00000020, "R11 mip unchanged");
    idle();
    repeat (3) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R12 missing responses got %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule